// File: doc/BRIEF.md
# Lamp ballast mode sequencer

A synchronous controller that walks a resonant lamp ballast through its operating modes. On power-up it waits in lockout with the bridge stopped. When the supply, the DC bus, the lamp-presence (shutdown) input and the die temperature are all good, it starts the oscillator in preheat at the preheat frequency. After a programmable number of clock cycles it moves to an ignition sweep, whose length is a quarter of the preheat length. It then settles in run mode at the run frequency.

Its inputs are single-bit flags from external comparators. Each flag passes through a two-flop synchronizer before the mode logic sees it. A supply dip, a bus dip or a lamp removal in any active mode drops the block back to lockout. That return is not latched, so the whole sequence starts over once conditions recover. Over-temperature, or a trip request from the current monitor during ignition or run, latches the block into fault mode. Fault mode is left only through the shutdown input or a supply collapse.

The outputs drive the oscillator enable, the two frequency selects and the two current-threshold enables. The present mode is also given as a 3-bit code.

Top module: `ballast_seq`

## Requirements
- R1: While rst_ni is low and right after it rises, mode_o is 0 (lockout) and every other output is low. Mode codes: 0 lockout, 1 preheat, 2 ignite, 3 run, 4 fault.
- R2: The block leaves lockout only for preheat, and only when vcc_on_i=1, bus_ok_i=1, shdn_i=0 and hot_i=0 hold together. If any one of them is missing, it stays in lockout.
- R3: In lockout (0) and in fault (4), osc_en_o, sel_preheat_o, sel_run_o, cs_over_en_o and cs_under_en_o are all 0.
- R4: Preheat (1) drives osc_en_o=1 and sel_preheat_o=1, with sel_run_o=0 and both current-threshold enables 0. It lasts max(P,1) cycles, where P is preheat_len_i sampled on the cycle that leaves lockout.
- R5: Ignite (2) follows preheat and lasts max(P>>2,1) cycles. It drives osc_en_o=1 and cs_over_en_o=1, with both frequency selects 0 and cs_under_en_o=0.
- R6: Run (3) follows ignite and is held indefinitely. It drives osc_en_o=1, sel_run_o=1, cs_over_en_o=1 and cs_under_en_o=1, with sel_preheat_o=0.
- R7: In preheat, ignite or run, vcc_low_i=1, bus_ok_i=0 or shdn_i=1 returns the block to lockout. This return takes precedence over any fault cause seen in the same cycle.
- R8: hot_i=1 in preheat, ignite or run enters fault (4). cs_trip_i=1 enters fault only from ignite or run; in preheat it has no effect.
- R9: Fault is left, to lockout, only when shdn_i=1 or vcc_low_i=1. Bus changes, temperature and current trips do not release it. A restart then needs the R2 conditions again, so shdn_i must be low once more.
- R10: Every flag input takes effect on the third rising clock edge after it changes. This is two synchronizer stages plus the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_on_i | input | 1 | Supply above the rising lockout limit |
| vcc_low_i | input | 1 | Supply below the falling lockout limit |
| bus_ok_i | input | 1 | DC bus above its good limit |
| shdn_i | input | 1 | Shutdown / lamp-absent input high |
| hot_i | input | 1 | Junction over-temperature |
| cs_trip_i | input | 1 | Fault request from the current monitor |
| preheat_len_i | input | CNT_W | Preheat length in clock cycles |
| mode_o | output | 3 | Present mode code |
| osc_en_o | output | 1 | Oscillator / bridge enable |
| sel_preheat_o | output | 1 | Select the preheat frequency |
| sel_run_o | output | 1 | Select the run frequency |
| cs_over_en_o | output | 1 | Enable the over-current threshold |
| cs_under_en_o | output | 1 | Enable the under-current threshold |

## Verification
Some properties are checked on every cycle. These are the conditions under which lockout may be left, and the forcing of lockout three edges after shutdown or supply-low. They also cover fault holding until its release, fault entry from a current trip in ignite or run, and the output masks per mode. Only the bench's scenarios show the preheat and ignition durations for several programmed lengths, including lengths of 0 and 3. They also show that a current trip during preheat is ignored and that the latched fault survives a bus dip. Finally they show restart after each kind of exit and abort precedence over a simultaneous trip. A behavioural model in the bench follows all of these cycle by cycle.

// File: rtl/ballast_pkg.sv
package ballast_pkg;
  typedef enum logic [2:0] {
    MODE_LOCK    = 3'd0,
    MODE_PREHEAT = 3'd1,
    MODE_IGNITE  = 3'd2,
    MODE_RUN     = 3'd3,
    MODE_FAULT   = 3'd4
  } mode_e;

  localparam int unsigned NUM_FLAGS = 6;
  localparam int unsigned F_VCC_ON  = 0;
  localparam int unsigned F_VCC_LOW = 1;
  localparam int unsigned F_BUS_OK  = 2;
  localparam int unsigned F_SHDN    = 3;
  localparam int unsigned F_HOT     = 4;
  localparam int unsigned F_CS_TRIP = 5;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mode_timer.sv
module mode_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_pre_i,
  input  logic             load_ign_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] tmr_q, ign_q;
  logic [CNT_W-1:0] pre_len, ign_len;

  // zero lengths run for a single cycle
  assign pre_len = (len_i == '0) ? ONE : len_i;
  assign ign_len = ((len_i >> 2) == '0) ? ONE : (len_i >> 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      ign_q <= '0;
    end else if (load_pre_i) begin
      tmr_q <= pre_len;
      ign_q <= ign_len;
    end else if (load_ign_i) begin
      tmr_q <= ign_q;
    end else if (dec_i) begin
      tmr_q <= tmr_q - ONE;
    end
  end

  assign done_o = (tmr_q <= ONE);
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import ballast_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  vcc_on_i,
  input  logic  vcc_low_i,
  input  logic  bus_ok_i,
  input  logic  shdn_i,
  input  logic  hot_i,
  input  logic  cs_trip_i,
  input  logic  done_i,
  output mode_e mode_o,
  output logic  load_pre_o,
  output logic  load_ign_o,
  output logic  dec_o
);
  mode_e state_q, state_d;
  logic  start_ok, abort, fault_req, active;

  assign active    = (state_q == MODE_PREHEAT) || (state_q == MODE_IGNITE) ||
                     (state_q == MODE_RUN);
  assign start_ok  = vcc_on_i && bus_ok_i && !shdn_i && !hot_i;
  assign abort     = vcc_low_i || !bus_ok_i || shdn_i;
  assign fault_req = hot_i ||
                     (cs_trip_i && (state_q == MODE_IGNITE || state_q == MODE_RUN));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_LOCK:    if (start_ok) state_d = MODE_PREHEAT;
      MODE_PREHEAT: if (done_i)   state_d = MODE_IGNITE;
      MODE_IGNITE:  if (done_i)   state_d = MODE_RUN;
      MODE_RUN:     state_d = MODE_RUN;
      MODE_FAULT:   if (shdn_i || vcc_low_i) state_d = MODE_LOCK;
      default:      state_d = MODE_LOCK;
    endcase
    // unlatched abort outranks a latched fault
    if (active) begin
      if (abort)          state_d = MODE_LOCK;
      else if (fault_req) state_d = MODE_FAULT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MODE_LOCK;
    else         state_q <= state_d;
  end

  assign mode_o     = state_q;
  assign load_pre_o = (state_q == MODE_LOCK) && (state_d == MODE_PREHEAT);
  assign load_ign_o = (state_q == MODE_PREHEAT) && (state_d == MODE_IGNITE);
  assign dec_o      = (state_q == MODE_PREHEAT || state_q == MODE_IGNITE) &&
                      (state_d == state_q);
endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import ballast_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vcc_on_i,
  input  logic             vcc_low_i,
  input  logic             bus_ok_i,
  input  logic             shdn_i,
  input  logic             hot_i,
  input  logic             cs_trip_i,
  input  logic [CNT_W-1:0] preheat_len_i,
  output logic [2:0]       mode_o,
  output logic             osc_en_o,
  output logic             sel_preheat_o,
  output logic             sel_run_o,
  output logic             cs_over_en_o,
  output logic             cs_under_en_o
);
  logic [NUM_FLAGS-1:0] flags_raw, flags_s;
  logic  load_pre, load_ign, dec, done;
  mode_e mode;

  always_comb begin
    flags_raw            = '0;
    flags_raw[F_VCC_ON]  = vcc_on_i;
    flags_raw[F_VCC_LOW] = vcc_low_i;
    flags_raw[F_BUS_OK]  = bus_ok_i;
    flags_raw[F_SHDN]    = shdn_i;
    flags_raw[F_HOT]     = hot_i;
    flags_raw[F_CS_TRIP] = cs_trip_i;
  end

  sync_bank #(.WIDTH(NUM_FLAGS), .STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (flags_raw),
    .q_o    (flags_s)
  );

  mode_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_pre_i (load_pre),
    .load_ign_i (load_ign),
    .dec_i      (dec),
    .len_i      (preheat_len_i),
    .done_o     (done)
  );

  mode_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vcc_on_i   (flags_s[F_VCC_ON]),
    .vcc_low_i  (flags_s[F_VCC_LOW]),
    .bus_ok_i   (flags_s[F_BUS_OK]),
    .shdn_i     (flags_s[F_SHDN]),
    .hot_i      (flags_s[F_HOT]),
    .cs_trip_i  (flags_s[F_CS_TRIP]),
    .done_i     (done),
    .mode_o     (mode),
    .load_pre_o (load_pre),
    .load_ign_o (load_ign),
    .dec_o      (dec)
  );

  assign mode_o        = mode;
  assign osc_en_o      = (mode == MODE_PREHEAT) || (mode == MODE_IGNITE) || (mode == MODE_RUN);
  assign sel_preheat_o = (mode == MODE_PREHEAT);
  assign sel_run_o     = (mode == MODE_RUN);
  assign cs_over_en_o  = (mode == MODE_IGNITE) || (mode == MODE_RUN);
  assign cs_under_en_o = (mode == MODE_RUN);
endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vcc_on_i,
  input logic       vcc_low_i,
  input logic       bus_ok_i,
  input logic       shdn_i,
  input logic       hot_i,
  input logic       cs_trip_i,
  input logic [2:0] mode_o,
  input logic       osc_en_o,
  input logic       sel_preheat_o,
  input logic       sel_run_o,
  input logic       cs_over_en_o,
  input logic       cs_under_en_o
);
  localparam logic [2:0] M_LOCK = 3'd0, M_PRE = 3'd1, M_IGN = 3'd2,
                         M_RUN = 3'd3, M_FLT = 3'd4;

  // R2
  start_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == M_LOCK && mode_o != M_LOCK) |->
      (mode_o == M_PRE && $past(vcc_on_i, 3) && $past(bus_ok_i, 3) &&
       !$past(shdn_i, 3) && !$past(hot_i, 3)));

  // R3
  idle_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_LOCK || mode_o == M_FLT) |->
      !(osc_en_o || sel_preheat_o || sel_run_o || cs_over_en_o || cs_under_en_o));

  // R4
  preheat_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_PRE) |-> (osc_en_o && !cs_over_en_o && !cs_under_en_o &&
                           $onehot0({sel_preheat_o, sel_run_o})));

  // R7
  shdn_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(shdn_i, 3) |-> (mode_o == M_LOCK));

  // R9
  vcc_low_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vcc_low_i, 3) |-> (mode_o == M_LOCK));

  // R9
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == M_FLT && !$past(shdn_i, 3) && !$past(vcc_low_i, 3)) |->
      (mode_o == M_FLT));

  // R8
  trip_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(mode_o) == M_IGN || $past(mode_o) == M_RUN) && $past(cs_trip_i, 3) &&
     !$past(vcc_low_i, 3) && $past(bus_ok_i, 3) && !$past(shdn_i, 3)) |->
      (mode_o == M_FLT));
endmodule

bind ballast_seq ballast_seq_chk i_chk (.*);

// File: tb/test_ballast_seq.sv
module test_ballast_seq;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vcc_on = 0, vcc_low = 0, bus_ok = 0, shdn = 0, hot = 0, cs_trip = 0;
  logic [CNT_W-1:0] plen = 16'd12;
  logic [2:0] mode;
  logic osc_en, sel_pre, sel_run, cs_over, cs_under;

  int total = 0, bad = 0, cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  ballast_seq #(.CNT_W(CNT_W)) i_ballast_seq (
    .clk_i(clk), .rst_ni(rst_n), .vcc_on_i(vcc_on), .vcc_low_i(vcc_low),
    .bus_ok_i(bus_ok), .shdn_i(shdn), .hot_i(hot), .cs_trip_i(cs_trip),
    .preheat_len_i(plen), .mode_o(mode), .osc_en_o(osc_en),
    .sel_preheat_o(sel_pre), .sel_run_o(sel_run), .cs_over_en_o(cs_over),
    .cs_under_en_o(cs_under)
  );

  // behavioural reference: flags seen two edges late, then mode update
  int m_state = 0, m_tmr = 0, m_ign = 0;
  logic [5:0] d1 = '0, d2 = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_tmr = 0; m_ign = 0; d1 = '0; d2 = '0;
    end else begin
      bit s_on, s_low, s_bus, s_shdn, s_hot, s_trip;
      {s_trip, s_hot, s_shdn, s_bus, s_low, s_on} = d2;
      case (m_state)
        0: if (s_on && s_bus && !s_shdn && !s_hot) begin
             m_state = 1;
             m_tmr = (plen == 0) ? 1 : int'(plen);
             m_ign = ((plen >> 2) == 0) ? 1 : int'(plen >> 2);
           end
        4: if (s_shdn || s_low) m_state = 0;
        default: begin
          if (s_low || !s_bus || s_shdn) m_state = 0;
          else if (s_hot || (s_trip && m_state != 1)) m_state = 4;
          else if (m_state == 1) begin
            if (m_tmr <= 1) begin m_state = 2; m_tmr = m_ign; end
            else m_tmr--;
          end else if (m_state == 2) begin
            if (m_tmr <= 1) m_state = 3;
            else m_tmr--;
          end
        end
      endcase
      d2 = d1;
      d1 = {cs_trip, hot, shdn, bus_ok, vcc_low, vcc_on};
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    int e = m_state;
    check(req, "mode", int'(mode), e);
    check(req, "osc_en", int'(osc_en), int'(e >= 1 && e <= 3));
    check(req, "sel_preheat", int'(sel_pre), int'(e == 1));
    check(req, "sel_run", int'(sel_run), int'(e == 3));
    check(req, "cs_over_en", int'(cs_over), int'(e == 2 || e == 3));
    check(req, "cs_under_en", int'(cs_under), int'(e == 3));
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) check_outs(cur_req);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_good();
    vcc_on = 1; vcc_low = 0; bus_ok = 1; shdn = 0; hot = 0; cs_trip = 0;
  endtask

  // count consecutive sampled cycles spent in mode m
  task automatic count_mode(int m, output int n);
    n = 0;
    while (int'(mode) == m && n < 70000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_mode(int m);
    int g = 0;
    while (int'(mode) != m && g < 70000) begin g++; @(negedge clk); end
  endtask

  task automatic run_seq(string req, int exp_pre, int exp_ign);
    int n;
    wait_mode(1);
    count_mode(1, n); check(req, "preheat cycles", n, exp_pre);
    count_mode(2, n); check(req, "ignite cycles", n, exp_ign);
    check(req, "mode after ignite", int'(mode), 3);
  endtask

  initial begin
    cyc(3);
    cur_req = "R1";
    check("R1", "mode in reset", int'(mode), 0);
    check("R1", "osc_en in reset", int'(osc_en), 0);
    check("R1", "cs_under in reset", int'(cs_under), 0);
    rst_n = 1;
    cyc(2);
    check("R1", "mode after reset", int'(mode), 0);

    // R2: each start condition missing in turn
    cur_req = "R2";
    all_good(); vcc_on = 0; cyc(8);
    all_good(); bus_ok = 0; cyc(8);
    all_good(); shdn = 1; cyc(8);
    all_good(); hot = 1; cyc(8);
    check("R2", "held in lockout", int'(mode), 0);
    vcc_on = 0; hot = 0; cyc(6);

    // R10: reaction on third edge
    cur_req = "R10";
    all_good(); cyc(2);
    check("R10", "mode after 2 edges", int'(mode), 0);
    cyc(1);
    check("R10", "mode after 3 edges", int'(mode), 1);

    // R4 R5 R6: P=12 with a current trip during preheat (R8: ignored)
    cur_req = "R8";
    cyc(2); cs_trip = 1; cyc(3); cs_trip = 0;
    cur_req = "R5";
    wait_mode(2); wait_mode(3);
    cur_req = "R6";
    cyc(10);
    check("R6", "run held", int'(mode), 3);

    // R7: bus dip aborts, restart with P=3 (ignite floor of 1)
    cur_req = "R7";
    plen = 16'd3; bus_ok = 0; cyc(4);
    check("R7", "lockout after bus dip", int'(mode), 0);
    bus_ok = 1;
    cur_req = "R4";
    run_seq("R4", 3, 1);

    // R8 R9: trip in run latches; bus dip does not release
    cur_req = "R8";
    cs_trip = 1; cyc(4); cs_trip = 0;
    check("R8", "fault from run trip", int'(mode), 4);
    cur_req = "R9";
    bus_ok = 0; cyc(5); bus_ok = 1; hot = 1; cyc(5); hot = 0; cyc(5);
    check("R9", "fault held", int'(mode), 4);
    check("R3", "osc off in fault", int'(osc_en), 0);
    shdn = 1; cyc(8);
    check("R9", "lockout while shdn high", int'(mode), 0);
    plen = 16'd0; shdn = 0;
    cur_req = "R5";
    run_seq("R5", 1, 1);

    // R8: over-temperature during preheat, release by supply low
    cur_req = "R8";
    plen = 16'd40; bus_ok = 0; cyc(4); bus_ok = 1;
    wait_mode(1); cyc(5); hot = 1; cyc(4); hot = 0;
    check("R8", "fault from hot preheat", int'(mode), 4);
    cur_req = "R9";
    vcc_on = 0; vcc_low = 1; cyc(5);
    check("R9", "lockout on supply low", int'(mode), 0);
    vcc_low = 0; vcc_on = 1;
    cur_req = "R6";
    run_seq("R6", 40, 10);

    // R7: shutdown and trip together in run -> lockout wins
    cur_req = "R7";
    shdn = 1; cs_trip = 1; cyc(4);
    check("R7", "abort beats trip", int'(mode), 0);
    shdn = 0; cs_trip = 0;
    cur_req = "R3";
    cyc(20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=0", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule